// File: doc/BRIEF.md
# STN Panel Line and Frame Timing Generator

This block produces every control waveform a dot-matrix STN panel needs to take in a frame. It pulls pixel data one group at a time from an upstream fetch port and presents the group on a 4-bit or 8-bit data bus, with a shift clock that rises while the data is stable. After the last group of a row it raises a latch pulse. The width of that pulse is programmable, so the row period, and with it the frame rate, can be tuned to the panel. A first-line marker accompanies the latch pulse of the first row of each frame. A separate line counter flips the AC alternation output after a programmable number of rows.

Each row is a fixed sequence. The shift phase takes two clock cycles per group: fetch and load, then a strobe. One tail cycle completes the last strobe. The latch pulse follows, then an idle gap whose length is set by configuration. The shift clock is held low throughout the latch pulse and the idle gap. Configuration is read continuously and is expected to stay constant while the panel is being driven.

Top module: `lcd_line_timer`

## Requirements
- R1: While `rst` is high, `lcd_cp`, `lcd_lp`, `lcd_flm`, `lcd_m`, `lcd_vd` and `fetch_req` all read 0 after the first clock edge.
- R2: Each row holds G groups, where G = `cfg_ppl`/8 when `cfg_wide`=1 and `cfg_ppl`/4 when `cfg_wide`=0, with a fraction dropped and G=0 treated as 1. Each row contains exactly G single-cycle `fetch_req` pulses and exactly G single-cycle `lcd_cp` pulses.
- R3: A group is loaded from `fetch_data` at the clock edge that ends its `fetch_req` cycle and stays on `lcd_vd` through the following `lcd_cp` high cycle. With `cfg_wide`=1, `lcd_vd` carries all 8 bits. With `cfg_wide`=0, `lcd_vd[3:0]` carries `fetch_data[3:0]` and `lcd_vd[7:4]` is 0.
- R4: `lcd_lp` rises in the cycle after the last `lcd_cp` pulse of a row and stays high for L = `cfg_lpw` cycles, with 0 treated as 1.
- R5: `lcd_cp` is never high in the same cycle as `lcd_lp`. It is low in the first cycle after `lcd_lp` falls, which starts the idle gap.
- R6: Consecutive rising edges of `lcd_lp` are exactly L + H + 1 + 2G + 1 cycles apart, where H = `cfg_hidle`.
- R7: Rows are counted modulo N = `cfg_lines`, with 0 treated as 1. `lcd_flm` is high exactly during the latch pulses of rows whose index is a multiple of N, the first row after reset being index 0, and is low at all other times.
- R8: `lcd_m` is 0 after reset. It toggles in the cycle after every P-th latch pulse ends, where P = `cfg_mper` with 0 treated as 1, counting latch pulses regardless of frame boundaries. At the rise of latch pulse k (from 0), `lcd_m` = (k/P) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 8-bit bus, 0: 4-bit bus |
| cfg_ppl | input | PPL_W (10) | Pixels per row |
| cfg_lines | input | LINE_W (9) | Rows per frame |
| cfg_lpw | input | LPW_W (4) | Latch pulse width in cycles |
| cfg_hidle | input | IDLE_W (4) | Extra idle cycles after the latch pulse |
| cfg_mper | input | MPER_W (6) | Rows between alternation toggles |
| fetch_req | output | 1 | Pixel group request; data is taken at the end of this cycle |
| fetch_data | input | 8 | Pixel group from the fetch side |
| lcd_cp | output | 1 | Shift clock to the panel |
| lcd_vd | output | 8 | Panel data bus |
| lcd_lp | output | 1 | Row latch pulse |
| lcd_flm | output | 1 | First-line marker |
| lcd_m | output | 1 | AC alternation signal |

## Verification
The bench builds the block with its default widths: 10-bit pixel count, 9-bit row count, 4-bit pulse and idle fields, and 6-bit alternation period. These are wide enough to walk six configurations with different group counts in both bus widths. The configurations also cover the zero-value corners that fall back to 1: a single group per row, a one-row frame, a one-cycle latch pulse and an alternation period of one row. The small counts keep each frame short, so twelve latch pulses per configuration take in several frame wraps and several alternation toggles.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;

    localparam int BUS_W = 8;
    localparam int NIB_W = 4;
    localparam int LANES = BUS_W / NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_LATCH = 2'd3
    } row_state_e;

    // Number of bus groups in one row; never zero.
    function automatic int unsigned groups_per_row(int unsigned ppl, logic wide);
        int unsigned g;
        g = wide ? (ppl / BUS_W) : (ppl / NIB_W);
        return (g == 0) ? 1 : g;
    endfunction

endpackage

// File: rtl/lcd_shift_path.sv
module lcd_shift_path
    import lcd_tim_pkg::*;
#(
    parameter int PPL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             wide,
    input  logic [PPL_W-1:0] ppl,
    input  logic [BUS_W-1:0] data_i,
    output logic             fetch_req,
    output logic             last_grp,
    output logic             cp,
    output logic [BUS_W-1:0] vd
);

    logic             ph;
    logic [PPL_W-1:0] grp;
    logic [PPL_W-1:0] grp_last;
    logic [BUS_W-1:0] vd_next;

    assign grp_last  = PPL_W'(groups_per_row(32'(ppl), wide) - 1);
    assign fetch_req = shift_en && !ph;
    assign last_grp  = shift_en && ph && (grp == grp_last);

    // Lane 0 always carries data; upper lanes only on the wide bus.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        if (n == 0) begin : g_base
            assign vd_next[n*NIB_W +: NIB_W] = data_i[n*NIB_W +: NIB_W];
        end else begin : g_upper
            assign vd_next[n*NIB_W +: NIB_W] = wide ? data_i[n*NIB_W +: NIB_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= 1'b0;
            grp <= '0;
            cp  <= 1'b0;
            vd  <= '0;
        end else begin
            cp <= shift_en && ph;
            if (shift_en) begin
                ph <= !ph;
                if (!ph) begin
                    vd <= vd_next;
                end else begin
                    grp <= last_grp ? '0 : grp + PPL_W'(1);
                end
            end else begin
                ph  <= 1'b0;
                grp <= '0;
            end
        end
    end

    // R3
    property vd_hold_p;
        @(posedge clk) disable iff (rst) $rose(cp) |-> $stable(vd);
    endproperty
    vd_hold_chk: assert property (vd_hold_p);

    // R2
    property fetch_single_p;
        @(posedge clk) disable iff (rst) fetch_req |=> !fetch_req;
    endproperty
    fetch_single_chk: assert property (fetch_single_p);

endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
    import lcd_tim_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int LPW_W  = 4,
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last_grp,
    input  logic [LINE_W-1:0] lines,
    input  logic [LPW_W-1:0]  lpw,
    input  logic [IDLE_W-1:0] hidle,
    output logic              shift_en,
    output logic              lp,
    output logic              flm,
    output logic              lp_end
);

    localparam int CNT_W = (LPW_W > IDLE_W) ? LPW_W : IDLE_W;

    row_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [LINE_W-1:0] row;
    logic [LPW_W-1:0]  lpw_eff;
    logic [LINE_W-1:0] row_last;

    assign lpw_eff  = (lpw == '0) ? LPW_W'(1) : lpw;
    assign row_last = (lines == '0) ? '0 : lines - LINE_W'(1);

    assign shift_en = (st == ST_SHIFT);
    assign lp       = (st == ST_LATCH);
    assign flm      = lp && (row == '0);
    assign lp_end   = lp && (cnt == CNT_W'(lpw_eff - LPW_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            row <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (cnt == CNT_W'(hidle)) begin
                        st  <= ST_SHIFT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (last_grp) st <= ST_TAIL;
                end
                ST_TAIL: begin
                    st  <= ST_LATCH;
                    cnt <= '0;
                end
                ST_LATCH: begin
                    if (lp_end) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                        row <= (row == row_last) ? '0 : row + LINE_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7
    property flm_inside_lp_p;
        @(posedge clk) disable iff (rst) flm |-> lp;
    endproperty
    flm_inside_lp_chk: assert property (flm_inside_lp_p);

endmodule

// File: rtl/lcd_alt_gen.sv
module lcd_alt_gen #(
    parameter int MPER_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_end,
    input  logic [MPER_W-1:0] mper,
    output logic              m
);

    logic [MPER_W-1:0] lcnt;
    logic [MPER_W-1:0] per_last;

    assign per_last = (mper == '0) ? '0 : mper - MPER_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt <= '0;
            m    <= 1'b0;
        end else if (lp_end) begin
            if (lcnt >= per_last) begin
                lcnt <= '0;
                m    <= !m;
            end else begin
                lcnt <= lcnt + MPER_W'(1);
            end
        end
    end

    // R8
    property m_moves_at_lp_end_p;
        @(posedge clk) disable iff (rst) (m != $past(m)) |-> $past(lp_end);
    endproperty
    m_moves_at_lp_end_chk: assert property (m_moves_at_lp_end_p);

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
    import lcd_tim_pkg::*;
#(
    parameter int PPL_W  = 10,
    parameter int LINE_W = 9,
    parameter int LPW_W  = 4,
    parameter int IDLE_W = 4,
    parameter int MPER_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic [PPL_W-1:0]  cfg_ppl,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic [LPW_W-1:0]  cfg_lpw,
    input  logic [IDLE_W-1:0] cfg_hidle,
    input  logic [MPER_W-1:0] cfg_mper,
    output logic              fetch_req,
    input  logic [BUS_W-1:0]  fetch_data,
    output logic              lcd_cp,
    output logic [BUS_W-1:0]  lcd_vd,
    output logic              lcd_lp,
    output logic              lcd_flm,
    output logic              lcd_m
);

    logic shift_en;
    logic last_grp;
    logic lp_end;

    lcd_shift_path #(.PPL_W(PPL_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .wide     (cfg_wide),
        .ppl      (cfg_ppl),
        .data_i   (fetch_data),
        .fetch_req(fetch_req),
        .last_grp (last_grp),
        .cp       (lcd_cp),
        .vd       (lcd_vd)
    );

    lcd_row_seq #(.LINE_W(LINE_W), .LPW_W(LPW_W), .IDLE_W(IDLE_W)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .last_grp(last_grp),
        .lines   (cfg_lines),
        .lpw     (cfg_lpw),
        .hidle   (cfg_hidle),
        .shift_en(shift_en),
        .lp      (lcd_lp),
        .flm     (lcd_flm),
        .lp_end  (lp_end)
    );

    lcd_alt_gen #(.MPER_W(MPER_W)) i_alt (
        .clk   (clk),
        .rst   (rst),
        .lp_end(lp_end),
        .mper  (cfg_mper),
        .m     (lcd_m)
    );

    // R5
    property cp_lp_apart_p;
        @(posedge clk) disable iff (rst) !(lcd_cp && lcd_lp);
    endproperty
    cp_lp_apart_chk: assert property (cp_lp_apart_p);

    // R5
    property cp_low_after_lp_p;
        @(posedge clk) disable iff (rst) $fell(lcd_lp) |-> !lcd_cp;
    endproperty
    cp_low_after_lp_chk: assert property (cp_low_after_lp_p);

endmodule

// File: tb/test_lcd_line_timer.sv
module test_lcd_line_timer;

    localparam int PPL_W  = 10;
    localparam int LINE_W = 9;
    localparam int LPW_W  = 4;
    localparam int IDLE_W = 4;
    localparam int MPER_W = 6;
    localparam int PULSES = 12;

    typedef struct packed {
        logic              wide;
        logic [PPL_W-1:0]  ppl;
        logic [LINE_W-1:0] lines;
        logic [LPW_W-1:0]  lpw;
        logic [IDLE_W-1:0] hidle;
        logic [MPER_W-1:0] mper;
        logic [7:0]        exp_g;
        logic [7:0]        exp_l;
        logic [7:0]        exp_n;
        logic [7:0]        exp_p;
        logic [15:0]       exp_period;
    } vec_t;

    // stimulus, then expected group count, pulse width, frame rows, alt period, row period
    localparam vec_t VECS [0:5] = '{
        '{1'b1, 10'd16, 9'd3, 4'd2, 4'd1, 6'd2, 8'd2, 8'd2, 8'd3, 8'd2, 16'd9},
        '{1'b0, 10'd16, 9'd3, 4'd2, 4'd1, 6'd2, 8'd4, 8'd2, 8'd3, 8'd2, 16'd13},
        '{1'b1, 10'd32, 9'd4, 4'd1, 4'd0, 6'd3, 8'd4, 8'd1, 8'd4, 8'd3, 16'd11},
        '{1'b0, 10'd8,  9'd2, 4'd5, 4'd3, 6'd1, 8'd2, 8'd5, 8'd2, 8'd1, 16'd14},
        '{1'b1, 10'd4,  9'd0, 4'd0, 4'd0, 6'd0, 8'd1, 8'd1, 8'd1, 8'd1, 16'd5},
        '{1'b1, 10'd24, 9'd5, 4'd3, 4'd2, 6'd4, 8'd3, 8'd3, 8'd5, 8'd4, 16'd13}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wide = 1'b1;
    logic [PPL_W-1:0]  cfg_ppl = '0;
    logic [LINE_W-1:0] cfg_lines = '0;
    logic [LPW_W-1:0]  cfg_lpw = '0;
    logic [IDLE_W-1:0] cfg_hidle = '0;
    logic [MPER_W-1:0] cfg_mper = '0;
    logic              fetch_req;
    logic [7:0]        fetch_data = '0;
    logic              lcd_cp;
    logic [7:0]        lcd_vd;
    logic              lcd_lp;
    logic              lcd_flm;
    logic              lcd_m;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = !clk;

    lcd_line_timer #(
        .PPL_W(PPL_W), .LINE_W(LINE_W), .LPW_W(LPW_W), .IDLE_W(IDLE_W), .MPER_W(MPER_W)
    ) i_lcd_line_timer (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_ppl(cfg_ppl),
        .cfg_lines(cfg_lines), .cfg_lpw(cfg_lpw), .cfg_hidle(cfg_hidle),
        .cfg_mper(cfg_mper), .fetch_req(fetch_req), .fetch_data(fetch_data),
        .lcd_cp(lcd_cp), .lcd_vd(lcd_vd), .lcd_lp(lcd_lp), .lcd_flm(lcd_flm),
        .lcd_m(lcd_m)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_reset_outputs();
        check(lcd_cp == 1'b0 && lcd_lp == 1'b0 && lcd_flm == 1'b0, "R1 cp/lp/flm",
              int'({lcd_cp, lcd_lp, lcd_flm}), 0);
        check(lcd_m == 1'b0 && fetch_req == 1'b0, "R1 m/fetch_req",
              int'({lcd_m, fetch_req}), 0);
        check(lcd_vd == 8'h00, "R1 vd", int'(lcd_vd), 0);
    endtask

    task automatic run_vec(input vec_t v);
        int fcnt = 0;
        int cyc = 0;
        int idx = 0;
        int cp_cnt = 0;
        int fr_cnt = 0;
        int lp_w = 0;
        int last_rise = 0;
        bit prev_cp = 0;
        bit prev_lp = 0;
        logic [7:0] last_fetch = '0;
        logic [7:0] pat;
        rst = 1'b1;
        cfg_wide = v.wide; cfg_ppl = v.ppl; cfg_lines = v.lines;
        cfg_lpw = v.lpw; cfg_hidle = v.hidle; cfg_mper = v.mper;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (idx < PULSES && cyc < 3000) begin
            @(negedge clk);
            // R5: shift clock and latch never overlap
            if (lcd_cp && lcd_lp) check(0, "R5 overlap", 1, 0);
            // R7: marker only within latch
            if (lcd_flm && !lcd_lp) check(0, "R7 flm outside lp", 1, 0);
            if (lcd_cp && !prev_cp) begin
                // R3: group on the bus during its strobe
                check(lcd_vd == last_fetch, "R3 vd at cp", int'(lcd_vd), int'(last_fetch));
                cp_cnt++;
            end
            if (!lcd_lp && prev_lp) begin
                // R4 width, R5 idle start
                check(lp_w == int'(v.exp_l), "R4 lp width", lp_w, int'(v.exp_l));
                check(!lcd_cp, "R5 cp in idle", int'(lcd_cp), 0);
            end
            if (lcd_lp && !prev_lp) begin
                check(cp_cnt == int'(v.exp_g), "R2 cp per row", cp_cnt, int'(v.exp_g));
                check(fr_cnt == int'(v.exp_g), "R2 fetch per row", fr_cnt, int'(v.exp_g));
                check(lcd_flm == ((idx % int'(v.exp_n)) == 0), "R7 flm",
                      int'(lcd_flm), int'((idx % int'(v.exp_n)) == 0));
                check(lcd_m == (((idx / int'(v.exp_p)) % 2) == 1), "R8 m",
                      int'(lcd_m), (idx / int'(v.exp_p)) % 2);
                if (idx > 0)
                    check(cyc - last_rise == int'(v.exp_period), "R6 row period",
                          cyc - last_rise, int'(v.exp_period));
                last_rise = cyc;
                idx++;
                cp_cnt = 0;
                fr_cnt = 0;
                lp_w = 0;
            end
            if (lcd_lp) lp_w++;
            pat = 8'(fcnt * 37 + 8'h5A);
            fetch_data = pat;
            if (fetch_req) begin
                last_fetch = v.wide ? pat : {4'h0, pat[3:0]};
                fr_cnt++;
                fcnt++;
            end
            prev_cp = lcd_cp;
            prev_lp = lcd_lp;
            cyc++;
        end
        check(idx == PULSES, "R6 pulses seen", idx, PULSES);
    endtask

    initial begin
        // R1: reset state at start
        repeat (3) @(negedge clk);
        check_reset_outputs();
        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i]);
        end
        // R1: reset applied mid-row clears everything
        rst = 1'b0;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_outputs();
        // R8 / R7: corner vector rerun after reset restarts counters from zero
        run_vec(VECS[4]);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule